// File: doc/BRIEF.md
# Raw Sensor Window Writer

This block sits behind the parallel input of an image sensor that delivers one raw sample per pixel clock, framed by a line sync and a frame sync. It cuts a rectangle out of each frame and turns every kept sample into a write request for memory. The rectangle is given by a first column, a column count, a first row and a row count. Both counts are written as the count minus one. Each kept sample is reduced to the selected input width, optionally inverted, zero-extended to 16 bits, and packed two per 32-bit word. Rows of the rectangle are laid out in memory from a base address, and each new row begins a programmable byte pitch after the start of the one before.

All settings, including the capture enable, are taken only on the rising edge of the frame sync. Software may therefore rewrite them at any moment, and a frame in progress never changes shape. When the last word of the rectangle has been issued, the block raises a one-cycle completion pulse. The memory side is a plain strobe with address and data, with no back-pressure.

Top module: `raw_cap_writer`

## Requirements
- R1: After reset `wr_req` and `frame_done` stay low, and no write is issued before the first rising edge of `sen_vd`.
- R2: Column index 0 is the sample presented in the cycle where `sen_hd` rises, and the index counts up by one each cycle after that. Row index 0 is the first `sen_hd` rise in the same cycle as, or later than, a `sen_vd` rise. A sample is kept only when its column lies in [x0, x0+xm1] and its row lies in [y0, y0+ym1].
- R3: Each kept sample is masked to the selected width and placed in bits 11:0 (or lower) of a 16-bit half, with the upper bits zero. The width code is 0 for 12 bits, 1 for 10 bits, 2 for 8 bits and 3 for 12 bits. When `cfg_inv` is 1, the bits inside the width are inverted.
- R4: Kept samples of a row are paired in arrival order, and the first of each pair goes in `wr_data[15:0]`. When a row holds an odd number of kept samples, its final word carries that sample in bits 15:0 and zero in bits 31:16.
- R5: Word k of rectangle row r is written at (base with bits 4:0 cleared) + r x (pitch with bits 1:0 cleared) + 4k.
- R6: Writes happen only in frames where `cap_en` was 1 at the `sen_vd` rising edge. Changing `cap_en` later in the frame has no effect on that frame.
- R7: Window, base, pitch, width code and inversion are all captured at the `sen_vd` rising edge. Changing them mid-frame leaves the current frame's writes unchanged.
- R8: `frame_done` is high for exactly one cycle, the cycle right after the write request carrying the last sample of the last rectangle row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| cap_en | input | 1 | Capture enable, taken at frame start |
| cfg_fmt | input | 2 | Input width code |
| cfg_inv | input | 1 | Invert sample bits |
| cfg_x0 | input | CNT_W | First kept column |
| cfg_xm1 | input | CNT_W | Kept columns minus one |
| cfg_y0 | input | CNT_W | First kept row |
| cfg_ym1 | input | CNT_W | Kept rows minus one |
| cfg_base | input | ADDR_W | Byte address of the rectangle (32-byte aligned use) |
| cfg_pitch | input | PITCH_W | Byte distance between row starts |
| sen_hd | input | 1 | Line sync, active on rising edge |
| sen_vd | input | 1 | Frame sync, active on rising edge |
| sen_pix | input | DATA_W | Raw sample |
| wr_req | output | 1 | Write strobe, one cycle per word |
| wr_addr | output | ADDR_W | Byte address of the word |
| wr_data | output | 32 | Two packed samples |
| frame_done | output | 1 | Rectangle complete pulse |

## Verification
The frame-start edge and the line-start edge can land on the same sample. In that cycle the block must load its new settings, open row 0, reset the column count and decide whether that very sample is kept. The bench provokes this by raising `sen_vd` together with the first `sen_hd` of a frame, with a rectangle anchored at column 0 and row 0. It judges the result by comparing every written address and data word against a model built from the settings present on that edge. A second frame in the same mode moves the rectangle to the right edge of the last row, so that row opening and rectangle completion are both exercised under the coincident edges.

// File: rtl/raw_cap_pkg.sv
`timescale 1ns/1ps
package raw_cap_pkg;

    localparam int SAMP_W = 16;

    typedef enum logic [1:0] {
        FMT_FULL  = 2'd0,
        FMT_DROP2 = 2'd1,
        FMT_DROP4 = 2'd2,
        FMT_SPARE = 2'd3
    } fmt_e;

    // Mask of the bits a sample keeps for a given width code.
    function automatic logic [SAMP_W-1:0] fmt_mask(input logic [1:0] code, input int unsigned dw);
        int unsigned w;
        case (fmt_e'(code))
            FMT_DROP2: w = dw - 2;
            FMT_DROP4: w = dw - 4;
            default:   w = dw;
        endcase
        return SAMP_W'((32'd1 << w) - 32'd1);
    endfunction

endpackage

// File: rtl/rcap_sync_track.sv
`timescale 1ns/1ps
module rcap_sync_track #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hd,
    input  logic             vd,
    output logic             hd_rise,
    output logic             vd_rise,
    output logic             line_ok,
    output logic [CNT_W-1:0] px_idx,
    output logic [CNT_W-1:0] ln_idx
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             hd;
        logic             vd;
        logic             pend;
        logic             ok;
        logic [CNT_W-1:0] px;
        logic [CNT_W-1:0] ln;
    } trk_t;

    trk_t s_q, s_d;

    always_comb begin
        s_d     = s_q;
        hd_rise = hd & ~s_q.hd;
        vd_rise = vd & ~s_q.vd;
        s_d.hd  = hd;
        s_d.vd  = vd;

        // frame start arms row 0 for the next line start
        if (vd_rise) begin
            s_d.pend = 1'b1;
            s_d.ok   = 1'b0;
        end

        if (hd_rise) begin
            s_d.px = '0;
            if (s_d.pend) begin
                s_d.ln   = '0;
                s_d.pend = 1'b0;
                s_d.ok   = 1'b1;
            end else if (s_q.ln != CNT_MAX) begin
                s_d.ln = s_q.ln + 1'b1;
            end
        end else if (s_q.px != CNT_MAX) begin
            s_d.px = s_q.px + 1'b1;
        end

        px_idx  = s_d.px;
        ln_idx  = s_d.ln;
        line_ok = s_d.ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{hd: 1'b0, vd: 1'b0, pend: 1'b0, ok: 1'b0, px: CNT_MAX, ln: '0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/rcap_window.sv
`timescale 1ns/1ps
module rcap_window #(
    parameter int CNT_W = 13
) (
    input  logic             on,
    input  logic             line_ok,
    input  logic [CNT_W-1:0] px_idx,
    input  logic [CNT_W-1:0] ln_idx,
    input  logic [CNT_W-1:0] x0,
    input  logic [CNT_W-1:0] xm1,
    input  logic [CNT_W-1:0] y0,
    input  logic [CNT_W-1:0] ym1,
    output logic             keep,
    output logic             px_last,
    output logic             ln_last,
    output logic             row_first,
    output logic             row_next
);

    localparam int EW = CNT_W + 1;

    logic [EW-1:0] x_end, y_end, px_e, ln_e;
    logic          in_x, in_y;

    always_comb begin
        x_end = {1'b0, x0} + {1'b0, xm1};
        y_end = {1'b0, y0} + {1'b0, ym1};
        px_e  = {1'b0, px_idx};
        ln_e  = {1'b0, ln_idx};

        in_x  = (px_idx >= x0) && (px_e <= x_end);
        in_y  = (ln_idx >= y0) && (ln_e <= y_end);

        keep      = on & line_ok & in_x & in_y;
        px_last   = (px_e == x_end);
        ln_last   = (ln_e == y_end);
        row_first = line_ok & (ln_idx == y0);
        row_next  = line_ok & (ln_idx > y0) & (ln_e <= y_end);
    end

endmodule

// File: rtl/rcap_pack_wr.sv
`timescale 1ns/1ps
module rcap_pack_wr #(
    parameter int DATA_W  = 12,
    parameter int CNT_W   = 13,
    parameter int ADDR_W  = 32,
    parameter int PITCH_W = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [DATA_W-1:0]                   pix,
    input  logic [1:0]                          fmt,
    input  logic                                inv,
    input  logic                                keep,
    input  logic                                px_last,
    input  logic                                ln_last,
    input  logic                                line_start,
    input  logic                                row_first,
    input  logic                                row_next,
    input  logic [ADDR_W-1:0]                   base_al,
    input  logic [PITCH_W-1:0]                  pitch_al,
    output logic                                wr_req,
    output logic [ADDR_W-1:0]                   wr_addr,
    output logic [2*raw_cap_pkg::SAMP_W-1:0]    wr_data,
    output logic                                frame_done
);

    localparam int SAMP_W = raw_cap_pkg::SAMP_W;
    localparam int WORD_W = 2 * SAMP_W;
    localparam int PAD_W  = SAMP_W - DATA_W;

    typedef struct packed {
        logic              half;
        logic [SAMP_W-1:0] hold;
        logic [CNT_W-1:0]  wcol;
        logic [ADDR_W-1:0] row;
        logic              req;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic              last;
        logic              done;
    } pk_t;

    pk_t               s_q, s_d;
    logic [SAMP_W-1:0] mask;
    logic [SAMP_W-1:0] samp;
    logic [WORD_W-1:0] word;
    logic              emit;

    always_comb begin
        mask = raw_cap_pkg::fmt_mask(fmt, DATA_W);
        samp = ({{PAD_W{1'b0}}, pix} ^ (inv ? mask : '0)) & mask;

        s_d      = s_q;
        s_d.req  = 1'b0;
        s_d.last = 1'b0;
        s_d.done = s_q.last;
        emit     = 1'b0;
        word     = '0;

        if (line_start) begin
            s_d.half = 1'b0;
            s_d.wcol = '0;
            if (row_first) begin
                s_d.row = base_al;
            end else if (row_next) begin
                s_d.row = s_q.row + ADDR_W'(pitch_al);
            end
        end

        if (keep) begin
            if (s_d.half) begin
                word     = {samp, s_d.hold};
                emit     = 1'b1;
                s_d.half = 1'b0;
            end else if (px_last) begin
                word = {{SAMP_W{1'b0}}, samp};
                emit = 1'b1;
            end else begin
                s_d.hold = samp;
                s_d.half = 1'b1;
            end
        end

        if (emit) begin
            s_d.req  = 1'b1;
            s_d.addr = s_d.row + (ADDR_W'(s_d.wcol) << 2);
            s_d.data = word;
            s_d.last = px_last & ln_last;
            s_d.wcol = s_d.wcol + 1'b1;
        end

        wr_req     = s_q.req;
        wr_addr    = s_q.addr;
        wr_data    = s_q.data;
        frame_done = s_q.done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/raw_cap_writer.sv
`timescale 1ns/1ps
module raw_cap_writer #(
    parameter int DATA_W  = 12,
    parameter int CNT_W   = 13,
    parameter int ADDR_W  = 32,
    parameter int PITCH_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_en,
    input  logic [1:0]         cfg_fmt,
    input  logic               cfg_inv,
    input  logic [CNT_W-1:0]   cfg_x0,
    input  logic [CNT_W-1:0]   cfg_xm1,
    input  logic [CNT_W-1:0]   cfg_y0,
    input  logic [CNT_W-1:0]   cfg_ym1,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [PITCH_W-1:0] cfg_pitch,
    input  logic               sen_hd,
    input  logic               sen_vd,
    input  logic [DATA_W-1:0]  sen_pix,
    output logic               wr_req,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [31:0]        wr_data,
    output logic               frame_done
);

    localparam int SAMP_W     = raw_cap_pkg::SAMP_W;
    localparam int WORD_W     = 2 * SAMP_W;
    localparam int BASE_ALIGN = 32;
    localparam int PITCH_ALIGN = 4;

    typedef struct packed {
        logic               on;
        logic [1:0]         fmt;
        logic               inv;
        logic [CNT_W-1:0]   x0;
        logic [CNT_W-1:0]   xm1;
        logic [CNT_W-1:0]   y0;
        logic [CNT_W-1:0]   ym1;
        logic [ADDR_W-1:0]  base;
        logic [PITCH_W-1:0] pitch;
    } cfg_t;

    cfg_t sh_q, sh_d, live, act;

    logic             hd_rise, vd_rise, line_ok;
    logic [CNT_W-1:0] px_idx, ln_idx;
    logic             keep, px_last, ln_last, row_first, row_next;

    rcap_sync_track #(.CNT_W(CNT_W)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .hd      (sen_hd),
        .vd      (sen_vd),
        .hd_rise (hd_rise),
        .vd_rise (vd_rise),
        .line_ok (line_ok),
        .px_idx  (px_idx),
        .ln_idx  (ln_idx)
    );

    // settings in force for the current sample: fresh on a frame edge
    always_comb begin
        live.on    = cap_en;
        live.fmt   = cfg_fmt;
        live.inv   = cfg_inv;
        live.x0    = cfg_x0;
        live.xm1   = cfg_xm1;
        live.y0    = cfg_y0;
        live.ym1   = cfg_ym1;
        live.base  = cfg_base & ~ADDR_W'(BASE_ALIGN - 1);
        live.pitch = cfg_pitch & ~PITCH_W'(PITCH_ALIGN - 1);
        act        = vd_rise ? live : sh_q;
        sh_d       = act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    rcap_window #(.CNT_W(CNT_W)) u_win (
        .on        (act.on),
        .line_ok   (line_ok),
        .px_idx    (px_idx),
        .ln_idx    (ln_idx),
        .x0        (act.x0),
        .xm1       (act.xm1),
        .y0        (act.y0),
        .ym1       (act.ym1),
        .keep      (keep),
        .px_last   (px_last),
        .ln_last   (ln_last),
        .row_first (row_first),
        .row_next  (row_next)
    );

    rcap_pack_wr #(
        .DATA_W  (DATA_W),
        .CNT_W   (CNT_W),
        .ADDR_W  (ADDR_W),
        .PITCH_W (PITCH_W)
    ) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix        (sen_pix),
        .fmt        (act.fmt),
        .inv        (act.inv),
        .keep       (keep),
        .px_last    (px_last),
        .ln_last    (ln_last),
        .line_start (hd_rise),
        .row_first  (row_first),
        .row_next   (row_next),
        .base_al    (act.base),
        .pitch_al   (act.pitch),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_done (frame_done)
    );

endmodule

// File: rtl/raw_cap_writer_chk.sv
`timescale 1ns/1ps
module raw_cap_writer_chk #(
    parameter int DATA_W = 12,
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_en,
    input logic              sen_vd,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic              frame_done
);

    localparam int SAMP_W = WORD_W / 2;
    localparam logic [SAMP_W-1:0] HALF_KEEP = {{(SAMP_W-DATA_W){1'b0}}, {DATA_W{1'b1}}};
    localparam logic [WORD_W-1:0] PAD_BITS  = ~{HALF_KEEP, HALF_KEEP};

    logic vd_q, en_q;

    // independent record of the enable seen at each frame edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vd_q <= 1'b0;
            en_q <= 1'b0;
        end else begin
            vd_q <= sen_vd;
            if (sen_vd && !vd_q) begin
                en_q <= cap_en;
            end
        end
    end

    p_done_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(wr_req));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    p_addr_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> ((wr_addr & ADDR_W'(3)) == '0));

    p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> ((wr_data & PAD_BITS) == '0));

    p_write_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> en_q);

endmodule

bind raw_cap_writer raw_cap_writer_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_en     (cap_en),
    .sen_vd     (sen_vd),
    .wr_req     (wr_req),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .frame_done (frame_done)
);

// File: tb/tb_raw_cap_writer.sv
`timescale 1ns/1ps
module tb_raw_cap_writer;

    localparam int DW = 12;
    localparam int CW = 13;
    localparam int AW = 32;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cap_en = 1'b0;
    logic [1:0]    cfg_fmt = '0;
    logic          cfg_inv = 1'b0;
    logic [CW-1:0] cfg_x0 = '0, cfg_xm1 = '0, cfg_y0 = '0, cfg_ym1 = '0;
    logic [AW-1:0] cfg_base = '0;
    logic [PW-1:0] cfg_pitch = '0;
    logic          sen_hd = 1'b0, sen_vd = 1'b0;
    logic [DW-1:0] sen_pix = '0;
    logic          wr_req, frame_done;
    logic [AW-1:0] wr_addr;
    logic [31:0]   wr_data;

    always #2 clk = ~clk;

    raw_cap_writer #(.DATA_W(DW), .CNT_W(CW), .ADDR_W(AW), .PITCH_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cfg_fmt(cfg_fmt), .cfg_inv(cfg_inv),
        .cfg_x0(cfg_x0), .cfg_xm1(cfg_xm1), .cfg_y0(cfg_y0), .cfg_ym1(cfg_ym1),
        .cfg_base(cfg_base), .cfg_pitch(cfg_pitch), .sen_hd(sen_hd), .sen_vd(sen_vd),
        .sen_pix(sen_pix), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_done(frame_done)
    );

    int n_tests = 0, n_fail = 0, cyc = 0, seed = 0;
    int rec_n = 0, done_n = 0, done_c = 0;
    logic [AW-1:0] rec_a [0:255];
    logic [31:0]   rec_d [0:255];
    int            rec_c [0:255];
    bit finished = 0;

    // settings at the frame edge, and the mid-frame replacement set
    logic f_en, f_inv; logic [1:0] f_fmt;
    int f_x0, f_xm1, f_y0, f_ym1; logic [AW-1:0] f_base; logic [PW-1:0] f_pitch;
    logic a_en; logic [CW-1:0] a_x0, a_y0; logic [AW-1:0] a_base;

    always @(negedge clk) begin
        cyc++;
        if (wr_req) begin
            if (rec_n < 256) begin
                rec_a[rec_n] = wr_addr;
                rec_d[rec_n] = wr_data;
                rec_c[rec_n] = cyc;
            end
            rec_n++;
        end
        if (frame_done) begin
            done_n++;
            done_c = cyc;
        end
    end

    function automatic logic [11:0] pixval(int l, int p);
        return 12'(l * 131 + p * 7 + seed);
    endfunction

    function automatic logic [15:0] fmtv(logic [11:0] x);
        int w;
        logic [15:0] m;
        w = (f_fmt == 2'd1) ? 10 : (f_fmt == 2'd2) ? 8 : 12;
        m = 16'((1 << w) - 1);
        return f_inv ? ((~{4'h0, x}) & m) : ({4'h0, x} & m);
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic snap();
        f_en = cap_en; f_fmt = cfg_fmt; f_inv = cfg_inv;
        f_x0 = int'(cfg_x0); f_xm1 = int'(cfg_xm1); f_y0 = int'(cfg_y0); f_ym1 = int'(cfg_ym1);
        f_base = cfg_base; f_pitch = cfg_pitch;
    endtask

    task automatic apply_alt();
        cap_en = a_en; cfg_x0 = a_x0; cfg_y0 = a_y0; cfg_base = a_base;
    endtask

    task automatic set_cfg(logic en, logic [1:0] fm, logic iv, int x0, int xm1, int y0, int ym1,
                           logic [AW-1:0] base, logic [PW-1:0] pitch);
        cap_en = en; cfg_fmt = fm; cfg_inv = iv;
        cfg_x0 = CW'(x0); cfg_xm1 = CW'(xm1); cfg_y0 = CW'(y0); cfg_ym1 = CW'(ym1);
        cfg_base = base; cfg_pitch = pitch;
    endtask

    task automatic run_frame(int nl, int ppl, bit vd_same, bit alt);
        rec_n = 0;
        done_n = 0;
        if (!vd_same) begin
            @(negedge clk); sen_vd = 1'b1; sen_hd = 1'b0; sen_pix = '0; snap();
            @(negedge clk); if (alt) apply_alt();
            @(negedge clk); sen_vd = 1'b0;
            @(negedge clk);
        end
        for (int l = 0; l < nl; l++) begin
            for (int c = 0; c < ppl + 4; c++) begin
                @(negedge clk);
                sen_hd  = (c == 0);
                sen_pix = (c < ppl) ? pixval(l, c) : '0;
                if (vd_same && l == 0) begin
                    sen_vd = (c < 3);
                    if (c == 0) snap();
                    if (c == 1 && alt) apply_alt();
                end
            end
        end
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); sen_hd = 1'b0; sen_pix = '0; sen_vd = 1'b0;
        end
    endtask

    task automatic check_frame(string req, int nl);
        int n = 0;
        logic [31:0] base_al, pitch_al, ea, ed;
        if (!f_en) begin
            chk(rec_n == 0, "R6", "writes in disabled frame", rec_n, 0);
            chk(done_n == 0, "R6", "done in disabled frame", done_n, 0);
            return;
        end
        base_al  = f_base & ~32'd31;
        pitch_al = 32'(f_pitch) & ~32'd3;
        for (int r = 0; r <= f_ym1; r++) begin
            int l = f_y0 + r;
            int k = 0;
            if (l >= nl) break;
            for (int p = f_x0; p <= f_x0 + f_xm1; p += 2) begin
                logic [15:0] lo, hi;
                lo = fmtv(pixval(l, p));
                hi = (p + 1 <= f_x0 + f_xm1) ? fmtv(pixval(l, p + 1)) : 16'h0;
                ea = base_al + 32'(r) * pitch_al + 32'(k * 4);
                ed = {hi, lo};
                if (n < rec_n) begin
                    chk(rec_a[n] == ea, req, "address", rec_a[n], ea);
                    chk(rec_d[n] == ed, req, "data", rec_d[n], ed);
                end
                n++;
                k++;
            end
        end
        chk(rec_n == n, req, "word count", rec_n, n);
        chk(done_n == 1, "R8", "done pulses", done_n, 1);
        if (rec_n > 0 && rec_n <= 256)
            chk(done_c == rec_c[rec_n-1] + 1, "R8", "done cycle", done_c, rec_c[rec_n-1] + 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(wr_req == 1'b0, "R1", "wr_req after reset", wr_req, 0);
        chk(frame_done == 1'b0, "R1", "frame_done after reset", frame_done, 0);
        // lines without any frame edge must write nothing
        set_cfg(1'b1, 2'd0, 1'b0, 0, 3, 0, 1, 32'h800, 16'h10);
        rec_n = 0; done_n = 0;
        for (int l = 0; l < 3; l++) begin
            for (int c = 0; c < 10; c++) begin
                @(negedge clk); sen_hd = (c == 0); sen_pix = pixval(l, c);
            end
        end
        repeat (4) @(negedge clk);
        sen_hd = 1'b0;
        chk(rec_n == 0, "R1", "writes before first VD", rec_n, 0);
        chk(done_n == 0, "R1", "done before first VD", done_n, 0);
    endtask

    task automatic t_basic();
        seed = 1;
        set_cfg(1'b1, 2'd0, 1'b0, 2, 5, 1, 2, 32'h1000, 16'h40);
        run_frame(5, 12, 1'b0, 1'b0);
        check_frame("R2/R4", 5);
    endtask

    task automatic t_odd_align();
        seed = 2;
        // 5 kept columns, unaligned base and pitch
        set_cfg(1'b1, 2'd0, 1'b0, 3, 4, 0, 1, 32'h2013, 16'h32);
        run_frame(3, 10, 1'b0, 1'b0);
        check_frame("R5", 3);
    endtask

    task automatic t_format();
        seed = 3;
        set_cfg(1'b1, 2'd1, 1'b1, 0, 7, 2, 1, 32'h400, 16'h20);
        run_frame(4, 10, 1'b0, 1'b0);
        check_frame("R3", 4);
        seed = 4;
        set_cfg(1'b1, 2'd2, 1'b0, 1, 6, 0, 2, 32'h600, 16'h20);
        run_frame(4, 10, 1'b0, 1'b0);
        check_frame("R3", 4);
        seed = 5;
        set_cfg(1'b1, 2'd3, 1'b1, 2, 3, 1, 1, 32'h700, 16'h10);
        run_frame(4, 10, 1'b0, 1'b0);
        check_frame("R3", 4);
    endtask

    task automatic t_enable();
        seed = 6;
        set_cfg(1'b0, 2'd0, 1'b0, 1, 3, 0, 1, 32'h900, 16'h10);
        a_en = 1'b1; a_x0 = cfg_x0; a_y0 = cfg_y0; a_base = cfg_base;
        run_frame(3, 8, 1'b0, 1'b1);
        check_frame("R6", 3);
        set_cfg(1'b1, 2'd0, 1'b0, 1, 3, 0, 1, 32'h900, 16'h10);
        a_en = 1'b0;
        run_frame(3, 8, 1'b0, 1'b1);
        check_frame("R6", 3);
    endtask

    task automatic t_shadow();
        seed = 7;
        set_cfg(1'b1, 2'd0, 1'b0, 1, 3, 1, 1, 32'h3000, 16'h10);
        a_en = 1'b1; a_x0 = CW'(4); a_y0 = CW'(0); a_base = 32'h5000;
        run_frame(4, 10, 1'b0, 1'b1);
        check_frame("R7", 4);
    endtask

    task automatic t_same_edge();
        seed = 8;
        set_cfg(1'b1, 2'd0, 1'b0, 0, 3, 0, 2, 32'h100, 16'h8);
        run_frame(3, 8, 1'b1, 1'b0);
        check_frame("R2", 3);
        seed = 9;
        // rectangle at the right edge of the last row
        set_cfg(1'b1, 2'd0, 1'b0, 4, 3, 2, 0, 32'h180, 16'h8);
        run_frame(3, 8, 1'b1, 1'b0);
        check_frame("R2", 3);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_odd_align();
        t_format();
        t_enable();
        t_shadow();
        t_same_edge();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule